// File: doc/BRIEF.md
# Round-Robin Lane Distributor

This block sits on the transmit side of a network interface that moves data over several parallel serial lanes. It accepts words from one sending channel over a valid/ready input. Each word goes whole to a single lane serializer. A run-time mask says which lanes belong to the channel. Successive words go to successive allocated lanes, and a round-robin pointer skips any lane whose serializer reports busy.

The serializers of all lanes listen to one shared data bus. The outputs of several such distributors are ORed together onto that bus, so an idle distributor drives zeros. A word is handed to its lane with a per-lane new/ack pair. The distributor raises new on the chosen lane and holds the word on the bus until that lane answers with ack. When the serializer acknowledges at once, a word takes two cycles: the accept cycle and one send cycle.

Top module: `lane_distributor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, lane_new is all zeros and bus_data is zero. The round-robin pointer starts at lane 0.
- R2: At most one bit of lane_new is set at a time. From the cycle after a word is accepted until that word is acknowledged, bus_data equals the accepted word.
- R3: Whenever no bit of lane_new is set, bus_data is all zeros.
- R4: A lane is usable when its bit in lane_mask is 1 and its bit in lane_busy is 0. An accepted word goes to the first usable lane at or after the pointer, counting upward from the pointer and wrapping from lane LANES-1 to lane 0. The bit of lane_new with that lane's index is raised in the next cycle. After each grant the pointer moves to the lane above the granted lane, wrapping to 0.
- R5: When no lane is usable, in_ready is 0 and no word is taken. This includes an all-zero lane_mask. The held word is accepted once a lane becomes usable.
- R6: lane_new and bus_data stay unchanged until the edge at which lane_ack of the selected lane is 1. They return to zero in the next cycle. in_ready is 0 while a word is being handed off, so words leave in the order they were accepted.
- R7: If lane_ack answers in the same cycle as lane_new, a word occupies exactly two cycles. in_ready may be 1 again in the cycle after the send cycle.
- R8: Changing lane_mask or lane_busy while a word is being handed off does not change the lane or the data of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word present |
| in_data | input | DATA_W | Upstream word |
| in_ready | output | 1 | Word taken at this edge when in_valid is 1 |
| lane_mask | input | LANES | Lanes allocated to this channel |
| lane_busy | input | LANES | Per-lane serializer busy indication |
| lane_new | output | LANES | Per-lane new-word request |
| lane_ack | input | LANES | Per-lane acknowledge from serializer |
| bus_data | output | DATA_W | Shared data bus, zero when idle |

## Verification
The hardest situation to reach is a grant that must wrap past busy or unallocated lanes from a pointer left behind by earlier traffic. The bench sweeps every allocation mask against several busy patterns. It carries the pointer over from one word to the next, so wrap-around starts from many pointer positions. A stalled acknowledge is held for several cycles while the mask is cleared underneath the pending word. This shows that a hand-off in flight keeps its lane and its data.

// File: rtl/lane_distributor.sv
module lane_distributor #(
  parameter int DATA_W = 32,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [LANES-1:0]  lane_busy,
  output logic [LANES-1:0]  lane_new,
  input  logic [LANES-1:0]  lane_ack,
  output logic [DATA_W-1:0] bus_data
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic              sending;
  logic [LW-1:0]     ptr, sel, pick;
  logic [DATA_W-1:0] word;
  logic              found;
  logic [LANES-1:0]  usable;

  assign usable = lane_mask & ~lane_busy;

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = ptr;
    for (int i = 0; i < LANES; i++) begin
      idx = int'(ptr) + i;
      if (idx >= LANES) idx = idx - LANES;
      if (!found && usable[idx]) begin
        found = 1'b1;
        pick  = LW'(idx);
      end
    end
  end

  assign in_ready = !sending && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      ptr     <= '0;
      sel     <= '0;
      word    <= '0;
    end else if (!sending) begin
      if (in_valid && in_ready) begin
        sending <= 1'b1;
        sel     <= pick;
        word    <= in_data;
        ptr     <= (pick == LW'(LANES - 1)) ? '0 : pick + 1'b1;
      end
    end else if (lane_ack[sel]) begin
      sending <= 1'b0;
      word    <= '0;
    end
  end

  assign bus_data = sending ? word : '0;
  assign lane_new = sending ? (LANES'(1) << sel) : '0;
endmodule

// File: rtl/lane_distributor_chk.sv
module lane_distributor_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic [LANES-1:0]  lane_mask,
  input logic [LANES-1:0]  lane_new,
  input logic [LANES-1:0]  lane_ack,
  input logic [DATA_W-1:0] bus_data
);
  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_new));

  assert_word_on_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bus_data == $past(in_data)));

  assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_new == '0) |-> (bus_data == '0));

  assert_grant_allocated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((lane_new & $past(lane_mask)) != '0));

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_new != '0) && ((lane_new & lane_ack) == '0)) |=>
      ($stable(lane_new) && $stable(bus_data)));

  assert_no_ready_while_sending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_new != '0) |-> !in_ready);
endmodule

bind lane_distributor lane_distributor_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .lane_mask(lane_mask), .lane_new(lane_new),
  .lane_ack(lane_ack), .bus_data(bus_data)
);

// File: tb/lane_distributor_tb.sv
module lane_distributor_tb;
  localparam int DW = 32;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic [NL-1:0] lane_mask, lane_busy, lane_new, lane_ack, hold;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int fails  = 0;
  int ref_ptr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign lane_ack = lane_new & ~hold;

  lane_distributor #(.DATA_W(DW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_mask(lane_mask), .lane_busy(lane_busy),
    .lane_new(lane_new), .lane_ack(lane_ack), .bus_data(bus_data)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_pick(int p, logic [NL-1:0] m, logic [NL-1:0] b);
    for (int k = 0; k < NL; k++) begin
      int idx = (p + k) % NL;
      if (m[idx] && !b[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic send(logic [DW-1:0] d);
    int exp;
    in_valid = 1'b1;
    in_data  = d;
    #1;
    exp = ref_pick(ref_ptr, lane_mask, lane_busy);
    chk(in_ready == (exp >= 0), "R5", "in_ready", in_ready, exp >= 0);
    if (exp < 0) begin
      in_valid = 1'b0;
      @(negedge clk);
      chk(lane_new == '0, "R5", "lane_new no lane", lane_new, 0);
      return;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(lane_new == (NL'(1) << exp), "R4", "lane_new", lane_new, NL'(1) << exp);
    chk(bus_data == d, "R2", "bus_data", bus_data, d);
    chk(!in_ready, "R6", "in_ready while sending", in_ready, 0);
    ref_ptr = (exp + 1) % NL;
    @(negedge clk);
    chk(lane_new == '0 && bus_data == '0, "R3", "idle after ack", bus_data, 0);
    chk(in_ready == (ref_pick(ref_ptr, lane_mask, lane_busy) >= 0), "R7",
        "ready after two cycles", in_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    lane_mask = '0; lane_busy = '0; hold = '0;
    repeat (3) @(negedge clk);
    chk(lane_new == '0 && bus_data == '0, "R1", "reset outputs", bus_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lane_new == '0 && bus_data == '0, "R1", "after reset", lane_new, 0);

    lane_mask = 8'h10;
    send(32'hCAFE0001);
    lane_mask = 8'hFF;
    send(32'hCAFE0002);

    for (int m = 0; m < 256; m++) begin
      for (int b = 0; b < 4; b++) begin
        lane_mask = NL'(m);
        lane_busy = (b == 0) ? '0 : NL'(b * 73 + m * 5);
        send({8'hA5, 8'(m), 8'(b), 8'h3C});
      end
    end
    lane_busy = '0;

    begin
      int exp;
      lane_mask = 8'hFF;
      hold = 8'hFF;
      exp = ref_pick(ref_ptr, lane_mask, lane_busy);
      in_valid = 1'b1; in_data = 32'h1234_5678;
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk(lane_new == (NL'(1) << exp), "R6", "held lane", lane_new, NL'(1) << exp);
        chk(bus_data == 32'h1234_5678, "R6", "held data", bus_data, 32'h1234_5678);
        lane_mask = '0;
        lane_busy = 8'hFF;
        @(negedge clk);
      end
      chk(lane_new == (NL'(1) << exp), "R8", "lane after mask change", lane_new, NL'(1) << exp);
      chk(bus_data == 32'h1234_5678, "R8", "data after mask change", bus_data, 32'h1234_5678);
      hold = '0;
      @(negedge clk);
      chk(lane_new == '0 && bus_data == '0, "R6", "release", lane_new, 0);
      ref_ptr = (exp + 1) % NL;
      lane_busy = '0;
    end

    lane_mask = '0;
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(!in_ready, "R5", "ready with empty mask", in_ready, 0);
      @(negedge clk);
      chk(lane_new == '0 && bus_data == '0, "R5", "no grant empty mask", lane_new, 0);
    end
    lane_mask = 8'h02;
    send(32'hDEAD_BEEF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule